// File: doc/BRIEF.md
# Monitor ADC Keyed Soft Reset and Status Registers

This block is the register front end of a monitoring-ADC controller. It decodes a simple single-cycle register bus and exposes two words. The first is a write-only trigger word at byte offset 0x00. Writing the exact key 0x0000_000A to it launches a reset pulse of fixed length. That pulse clears the controller's own flags and its converter-side handshake outputs. The state owned by the test port is left alone.

The second word, at byte offset 0x04, is a read-only status word. It shows:
- latched per-channel completion flags,
- end-of-conversion and end-of-sequence flags,
- the live ADC busy line,
- three flags for arbitration with the test port.

The block also decides whether a configuration access issued from the fabric side succeeds or is refused. An access is refused while the test port holds its lock on the configuration port. A sticky "changed by test port" flag stays set until a fabric-side access succeeds.

The converter, the bus adapter and the test-port logic sit outside this block. They appear only as strobes and level inputs.

Top module: `mon_ctl_regs`

## Requirements
- R1: A write to offset 0x00 starts a reset pulse only when the data equals 0x0000_000A. Any other value written there, and the key written to any other offset, leaves `soft_rst` low.
- R2: `soft_rst` is high for exactly 16 cycles, starting in the cycle after the key write. A key write made while the pulse is high restarts the 16-cycle count.
- R3: A read of offset 0x00, or of any unmapped offset, returns zero. Status bits 31 to 11 always read as zero.
- R4: A write to offset 0x04, whatever its value, does not change the status word.
- R5: Three status bits follow their inputs in the same cycle: bit 10 follows `tp_busy`, bit 8 follows `tp_lock`, and bit 7 follows `adc_busy`.
- R6: Status bit 9 (test-port-modified) reads 1 from the cycle after a `tp_cfg_wr` strobe. It clears after a successful fabric access. The soft reset does not clear it, and it is 0 after `rst_n`.
- R7: A `cfg_req` made while `tp_lock` is 0 gives a one-cycle `cfg_ok` in the next cycle. A `cfg_req` made while `tp_lock` is 1 gives a one-cycle `cfg_err` instead and leaves bit 9 unchanged.
- R8: Status bits 6 to 0 are sticky flags, each set in the cycle after its strobe. Bit 6 is end-of-sequence, bit 5 is end-of-conversion, and bits 4..0 are channel 4..0 done. The soft reset and `rst_n` clear them.
- R9: While `soft_rst` is high, `cfg_req` produces neither `cfg_ok` nor `cfg_err`, and event strobes set no flag.
- R10: When `tp_cfg_wr` and a successful `cfg_req` occur in the same cycle, bit 9 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read enable |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd_en` |
| ch_done | input | 5 | Per-channel completion strobes |
| eoc_strobe | input | 1 | End-of-conversion strobe |
| eos_strobe | input | 1 | End-of-sequence strobe |
| adc_busy | input | 1 | Converter busy level |
| tp_busy | input | 1 | Test-port configuration transaction in progress |
| tp_lock | input | 1 | Test port holds the configuration-port lock |
| tp_cfg_wr | input | 1 | Test port wrote the configuration port |
| cfg_req | input | 1 | Fabric-side configuration access request |
| cfg_ok | output | 1 | Fabric access completed successfully |
| cfg_err | output | 1 | Fabric access refused because of the lock |
| soft_rst | output | 1 | Keyed soft reset pulse to the converter side |

## Verification
The hardest state to reach is a pulse that has been restarted in mid-flight. A second key write must land several cycles into a running pulse, and the bench must then count the stretched window cycle by cycle.

The bench also has to drive some interactions in a precise order. It sets the sticky modified flag and then sends refused and accepted fabric requests while the lock input changes. It fires a soft reset and checks that the test-port flag survives it. Finally, it makes the set and clear of the modified flag land in the same cycle.

// File: rtl/mon_ctl_pkg.sv
// Package: shared constants for the monitor ADC register block.
// Assumes byte addressing with 32-bit words; the status bit layout is fixed.
package mon_ctl_pkg;
    localparam int          DATA_W       = 32;
    localparam int          NUM_CH       = 5;
    localparam int          NUM_EVT      = NUM_CH + 2;
    localparam logic [31:0] RESET_KEY    = 32'h0000_000A;
    localparam int          OFS_TRIGGER  = 'h00;
    localparam int          OFS_STATUS   = 'h04;
    localparam int          BIT_EOC      = 5;
    localparam int          BIT_EOS      = 6;
    localparam int          BIT_ADC_BUSY = 7;
    localparam int          BIT_TP_LOCK  = 8;
    localparam int          BIT_TP_MOD   = 9;
    localparam int          BIT_TP_BUSY  = 10;
endpackage

// File: rtl/mon_softrst_gen.sv
// Module: mon_softrst_gen
// Produces a high pulse lasting CYCLES clocks after each fire strobe.
// A fire while the pulse is active reloads the count.
// Assumes CYCLES >= 1.
module mon_softrst_gen #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int              CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] remain_q;

    // Count down the remaining pulse cycles; reload on every fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (fire) begin
            remain_q <= LOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign active = (remain_q != '0);
endmodule

// File: rtl/mon_event_flags.sv
// Module: mon_event_flags
// A bank of N sticky flags. Each flag is set by its one-cycle strobe.
// The clear input has priority over the strobes.
// Assumes the strobes are synchronous to clk.
module mon_event_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] strobe,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Hold one sticky flag; clear dominates set.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                flags[g] <= 1'b0;
            end else if (strobe[g]) begin
                flags[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mon_tp_arbiter.sv
// Module: mon_tp_arbiter
// Judges fabric configuration requests against the test-port lock.
// Keeps the sticky "modified by test port" flag.
// The soft reset blocks new fabric requests but does not touch the
// test-port flag. Assumes single-cycle request strobes.
module mon_tp_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic tp_cfg_wr,
    input  logic tp_lock,
    input  logic cfg_req,
    output logic tp_modified,
    output logic cfg_ok,
    output logic cfg_err
);
    logic accept;
    logic grant_d;
    logic refuse_d;

    // Split an accepted request into its granted and refused cases.
    always_comb begin
        accept   = cfg_req && !soft_rst;
        grant_d  = accept && !tp_lock;
        refuse_d = accept && tp_lock;
    end

    // Register the one-cycle completion outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ok  <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            cfg_ok  <= grant_d;
            cfg_err <= refuse_d;
        end
    end

    // Sticky modified flag: set by a test-port write, cleared by a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_modified <= 1'b0;
        end else if (tp_cfg_wr) begin
            tp_modified <= 1'b1;
        end else if (grant_d) begin
            tp_modified <= 1'b0;
        end
    end
endmodule

// File: rtl/mon_ctl_regs.sv
// Module: mon_ctl_regs (top)
// Register front end of the monitor ADC controller.
// The trigger word at 0x00 takes only the key and reads as zero.
// The status word at 0x04 is read-only.
// Assumes a single-cycle bus: writes take effect at the clock edge and
// reads are combinational while bus_rd_en is high.
module mon_ctl_regs
    import mon_ctl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic              eoc_strobe,
    input  logic              eos_strobe,
    input  logic              adc_busy,
    input  logic              tp_busy,
    input  logic              tp_lock,
    input  logic              tp_cfg_wr,
    input  logic              cfg_req,
    output logic              cfg_ok,
    output logic              cfg_err,
    output logic              soft_rst
);
    localparam logic [ADDR_W-1:0] A_TRIGGER = ADDR_W'(OFS_TRIGGER);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);

    logic               key_fire;
    logic [NUM_EVT-1:0] evt_strobe;
    logic [NUM_EVT-1:0] evt_flags;
    logic               tp_modified;
    logic [DATA_W-1:0]  status_word;

    // Detect an exact key write to the trigger offset.
    always_comb begin
        key_fire = bus_wr_en && (bus_addr == A_TRIGGER) && (bus_wdata == RESET_KEY);
    end

    mon_softrst_gen #(.CYCLES(RST_CYCLES)) u_rstgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (key_fire),
        .active (soft_rst)
    );

    // Collect the event strobes in status bit order.
    always_comb begin
        evt_strobe = {eos_strobe, eoc_strobe, ch_done};
    end

    mon_event_flags #(.N(NUM_EVT)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst),
        .strobe (evt_strobe),
        .flags  (evt_flags)
    );

    mon_tp_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .tp_cfg_wr   (tp_cfg_wr),
        .tp_lock     (tp_lock),
        .cfg_req     (cfg_req),
        .tp_modified (tp_modified),
        .cfg_ok      (cfg_ok),
        .cfg_err     (cfg_err)
    );

    // Assemble the status word; unused upper bits stay zero.
    always_comb begin
        status_word                   = '0;
        status_word[NUM_EVT-1:0]      = evt_flags;
        status_word[BIT_ADC_BUSY]     = adc_busy;
        status_word[BIT_TP_LOCK]      = tp_lock;
        status_word[BIT_TP_MOD]       = tp_modified;
        status_word[BIT_TP_BUSY]      = tp_busy;
    end

    // Read mux: only the status offset returns data.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd_en && (bus_addr == A_STATUS)) begin
            bus_rdata = status_word;
        end
    end
endmodule

// File: rtl/mon_ctl_regs_chk.sv
// Module: mon_ctl_regs_chk
// Assertion checker bound to mon_ctl_regs.
// Assumes it observes the top's ports and its internal flag bank.
module mon_ctl_regs_chk
    import mon_ctl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int RST_CYCLES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_en,
    input logic               bus_rd_en,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               adc_busy,
    input logic               tp_busy,
    input logic               tp_lock,
    input logic               tp_cfg_wr,
    input logic               cfg_req,
    input logic               cfg_ok,
    input logic               cfg_err,
    input logic               soft_rst,
    input logic [NUM_EVT-1:0] evt_flags
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic          key_seen;
    logic [CW-1:0] win_q;

    // Detect a key write independently of the design's decode.
    always_comb begin
        key_seen = bus_wr_en && (bus_addr == ADDR_W'(OFS_TRIGGER)) && (bus_wdata == RESET_KEY);
    end

    // Track the expected pulse window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (key_seen) begin
            win_q <= CW'(RST_CYCLES);
        end else if (win_q != '0) begin
            win_q <= win_q - 1'b1;
        end
    end

    p_nonkey_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !key_seen && !soft_rst) |=> !soft_rst);

    p_pulse_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst == (win_q != '0));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:BIT_TP_BUSY+1] == '0);

    p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == ADDR_W'(OFS_STATUS)) |->
        (bus_rdata[BIT_TP_BUSY] == tp_busy && bus_rdata[BIT_TP_LOCK] == tp_lock
         && bus_rdata[BIT_ADC_BUSY] == adc_busy));

    p_mod_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tp_cfg_wr |=> (bus_rd_en && bus_addr == ADDR_W'(OFS_STATUS)) |-> bus_rdata[BIT_TP_MOD]);

    p_lock_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && tp_lock && !soft_rst) |=> (cfg_err && !cfg_ok));

    p_outcome_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cfg_ok, cfg_err}) <= 1);

    p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (evt_flags == '0));

    p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!cfg_ok && !cfg_err));
endmodule

bind mon_ctl_regs mon_ctl_regs_chk #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .adc_busy  (adc_busy),
    .tp_busy   (tp_busy),
    .tp_lock   (tp_lock),
    .tp_cfg_wr (tp_cfg_wr),
    .cfg_req   (cfg_req),
    .cfg_ok    (cfg_ok),
    .cfg_err   (cfg_err),
    .soft_rst  (soft_rst),
    .evt_flags (evt_flags)
);

// File: tb/mon_ctl_regs_tb_top.sv
// Directed bench for mon_ctl_regs: one task per scenario.
module mon_ctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr_en, bus_rd_en;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [4:0]  ch_done;
    logic        eoc_strobe, eos_strobe, adc_busy, tp_busy, tp_lock, tp_cfg_wr, cfg_req;
    logic        cfg_ok, cfg_err, soft_rst;

    int checks   = 0;
    int failures = 0;

    localparam logic [31:0] KEY = 32'h0000_000A;

    always #4 clk = ~clk;

    mon_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_done(ch_done), .eoc_strobe(eoc_strobe), .eos_strobe(eos_strobe),
        .adc_busy(adc_busy), .tp_busy(tp_busy), .tp_lock(tp_lock),
        .tp_cfg_wr(tp_cfg_wr), .cfg_req(cfg_req), .cfg_ok(cfg_ok),
        .cfg_err(cfg_err), .soft_rst(soft_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        bus_rd_en = 1'b1; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_rd_en = 1'b0;
    endtask

    task automatic soft_clear();
        bus_write(8'h00, KEY);
        repeat (16) step();
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        bus_read(8'h04, v);
        chk("R8 reset status", v, 32'h0);
        chk("R2 reset soft_rst", {31'b0, soft_rst}, 32'h0);
        chk("R7 reset outcome", {30'b0, cfg_ok, cfg_err}, 32'h0);
    endtask

    task automatic t_nonkey_r1();
        logic [31:0] v;
        bus_write(8'h00, 32'h0000_000B);
        chk("R1 wrong value", {31'b0, soft_rst}, 32'h0);
        bus_write(8'h00, 32'h1000_000A);
        chk("R1 high bits set", {31'b0, soft_rst}, 32'h0);
        bus_write(8'h04, KEY);
        chk("R1 key at status offset", {31'b0, soft_rst}, 32'h0);
        bus_read(8'h00, v);
        chk("R3 trigger reads zero", v, 32'h0);
        bus_read(8'h08, v);
        chk("R3 unmapped reads zero", v, 32'h0);
    endtask

    task automatic t_pulse_r2();
        int highs = 0;
        bus_write(8'h00, KEY);
        for (int i = 0; i < 16; i++) begin
            if (soft_rst === 1'b1) highs++;
            step();
        end
        chk("R2 high cycles", highs, 16);
        chk("R2 released", {31'b0, soft_rst}, 32'h0);
    endtask

    task automatic t_restart_r2();
        int highs = 0;
        bus_write(8'h00, KEY);
        repeat (5) step();
        bus_write(8'h00, KEY);
        for (int i = 0; i < 16; i++) begin
            if (soft_rst === 1'b1) highs++;
            step();
        end
        chk("R2 restarted window", highs, 16);
        chk("R2 restarted release", {31'b0, soft_rst}, 32'h0);
    endtask

    task automatic t_flags_r8();
        logic [31:0] v;
        ch_done = 5'b00001; step(); ch_done = '0;
        bus_read(8'h04, v);
        chk("R8 ch0 flag", v, 32'h01);
        ch_done = 5'b10000; eos_strobe = 1'b1; step();
        ch_done = '0; eos_strobe = 1'b0;
        bus_read(8'h04, v);
        chk("R8 ch4 and eos", v, 32'h51);
        eoc_strobe = 1'b1; step(); eoc_strobe = 1'b0;
        bus_read(8'h04, v);
        chk("R8 eoc added", v, 32'h71);
        soft_clear();
        bus_read(8'h04, v);
        chk("R8 cleared by soft reset", v, 32'h0);
    endtask

    task automatic t_readonly_r4();
        logic [31:0] v;
        ch_done = 5'b00100; step(); ch_done = '0;
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h04, 32'h0);
        bus_read(8'h04, v);
        chk("R4 status unchanged by writes", v, 32'h04);
        soft_clear();
    endtask

    task automatic t_mirror_r5();
        logic [31:0] v;
        adc_busy = 1'b1; tp_busy = 1'b1;
        bus_read(8'h04, v);
        chk("R5 busy bits", v, 32'h480);
        adc_busy = 1'b0; tp_busy = 1'b0; tp_lock = 1'b1;
        bus_read(8'h04, v);
        chk("R5 lock bit", v, 32'h100);
        tp_lock = 1'b0;
    endtask

    task automatic t_mod_lock_r6_r7();
        logic [31:0] v;
        tp_cfg_wr = 1'b1; step(); tp_cfg_wr = 1'b0;
        bus_read(8'h04, v);
        chk("R6 modified set", v, 32'h200);
        tp_lock = 1'b1;
        cfg_req = 1'b1; step(); cfg_req = 1'b0;
        chk("R7 refused outcome", {30'b0, cfg_ok, cfg_err}, 32'h1);
        bus_read(8'h04, v);
        chk("R7 modified kept when locked", v, 32'h300);
        step();
        chk("R7 error one cycle", {31'b0, cfg_err}, 32'h0);
        tp_lock = 1'b0;
        soft_clear();
        bus_read(8'h04, v);
        chk("R6 survives soft reset", v, 32'h200);
        cfg_req = 1'b1; step(); cfg_req = 1'b0;
        chk("R7 granted outcome", {30'b0, cfg_ok, cfg_err}, 32'h2);
        bus_read(8'h04, v);
        chk("R6 cleared by grant", v, 32'h0);
        step();
        chk("R7 ok one cycle", {31'b0, cfg_ok}, 32'h0);
    endtask

    task automatic t_blocked_r9();
        logic [31:0] v;
        bus_write(8'h00, KEY);
        cfg_req = 1'b1; ch_done = 5'b00010; step();
        cfg_req = 1'b0; ch_done = '0;
        chk("R9 no outcome during reset", {30'b0, cfg_ok, cfg_err}, 32'h0);
        repeat (16) step();
        bus_read(8'h04, v);
        chk("R9 strobe ignored during reset", v, 32'h0);
    endtask

    task automatic t_same_cycle_r10();
        logic [31:0] v;
        tp_cfg_wr = 1'b1; cfg_req = 1'b1; step();
        tp_cfg_wr = 1'b0; cfg_req = 1'b0;
        chk("R10 grant still issued", {31'b0, cfg_ok}, 32'h1);
        bus_read(8'h04, v);
        chk("R10 set wins", v, 32'h200);
    endtask

    initial begin
        rst_n = 1'b0; bus_wr_en = 0; bus_rd_en = 0; bus_addr = '0; bus_wdata = '0;
        ch_done = '0; eoc_strobe = 0; eos_strobe = 0; adc_busy = 0; tp_busy = 0;
        tp_lock = 0; tp_cfg_wr = 0; cfg_req = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset_state();
        t_nonkey_r1();
        t_pulse_r2();
        t_restart_r2();
        t_flags_r8();
        t_readonly_r4();
        t_mirror_r5();
        t_mod_lock_r6_r7();
        t_blocked_r9();
        t_same_cycle_r10();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule